// File: doc/BRIEF.md
# Conditional Set, Clear and Invert Unit

This block tests one of sixteen condition codes against four status flags: negative, overflow, zero and carry. It uses the result in two ways. For a modify request, it computes a new byte or word destination value by setting, clearing or inverting bits. For a branch request, it decodes a one-byte branch opcode and reports whether the branch is taken. An execution pipeline uses it after the operand has been fetched. The pipeline writes the returned value back when the write-enable is high, and it applies the taken signal to its own program-counter logic.

For a modify request, the immediate mask decides the behaviour. A mask of zero asks for a boolean result, or for a full complement in the invert form. A non-zero mask asks for a change to only the selected bits, made only when the condition holds. In byte size, only the low byte of the mask and of the destination takes part, and the upper byte is copied to the output unchanged.

Requests enter on a valid/ready port and results leave on a valid/ready port, through one output register. The upstream side may present a request at any time. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or the consumer is taking the current result, so a full register with `out_ready` low stalls the input. While it is stalled, the result stays constant.

Top module: `cond_sci_unit`

## Requirements
- R1: The condition codes are as follows.
  - 0: always.
  - 1: C=0.
  - 2: C=1.
  - 3: C=0 or Z=1.
  - 4: C=1 and Z=0.
  - 5: N xor V.
  - 6: N xnor V.
  - 7: Z=1 or (N xor V).
  - 8: Z=0 and N equals V.
  - 9: Z=1.
  - A: Z=0.
  - B: N=1.
  - C: N=0.
  - D: V=0.
  - E: V=1.
  - F: never.

  The flags input is ordered [3]=N, [2]=V, [1]=Z, [0]=C.
- R2: The op encoding is 0 set, 1 clear, 2 invert and 3 reserved. For set with an effective mask of zero, the output is 1 when the condition holds and 0 otherwise, with write-enable 1.
- R3: For clear with an effective mask of zero, the output is 0 when the condition holds and 1 otherwise, with write-enable 1.
- R4: For invert with an effective mask of zero, the output is the complement of the destination when the condition holds. Otherwise the destination is returned unchanged with write-enable 0.
- R5: With a non-zero effective mask, the three forms act only when the condition holds, with write-enable 1.
  - Set ORs the mask into the destination.
  - Clear clears the masked bits.
  - Invert XORs the mask into the destination.

  Otherwise the destination is returned with write-enable 0.
- R6: In byte size (`in_size_word`=0), the effective mask is the low 8 bits of the mask. The boolean or complement result applies to the low byte only, and output bits 15:8 equal destination bits 15:8.
- R7: A branch request (`in_kind`=1) is decoded from its opcode.
  - Opcode low five bits 0x1C select condition {0,top3}.
  - Opcode low five bits 0x1D select condition {1,top3}.

  Taken follows that condition. A branch request never writes (write-enable 0) and returns the destination.
- R8: The branch opcode 0xFD (class 0x1D, top bits 111) is taken regardless of the flags.
- R9: A branch opcode whose low five bits are neither 0x1C nor 0x1D is not taken. A modify request always returns taken 0.
- R10: A result appears on the output one cycle after acceptance. While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and the output fields hold steady.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.
- R12: The reserved op 3 returns the destination with write-enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_kind | input | 1 | 0 modify, 1 branch |
| in_opc | input | 8 | Branch opcode byte |
| in_flags | input | 4 | N,V,Z,C flags |
| in_cond | input | 4 | Condition code for modify |
| in_op | input | 2 | 0 set, 1 clear, 2 invert, 3 reserved |
| in_size_word | input | 1 | 1 word, 0 byte |
| in_mask | input | 16 | Immediate mask |
| in_dest | input | 16 | Current destination value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | 16 | New destination value |
| out_we | output | 1 | Write-enable for the destination |
| out_taken | output | 1 | Branch taken |

## Verification
Every result is due exactly one rising edge after the request is accepted. The bench therefore drives each request at a falling edge and samples `out_data`, `out_we` and `out_taken` at the next falling edge, half a period after the capturing edge. For the stall case, the bench holds `out_ready` low over several edges and compares the outputs each cycle against the first captured result, while it checks that `in_ready` is 0. A new request presented during the stall must show up only one edge after `out_ready` rises.

// File: rtl/cond_sci_pkg.sv
package cond_sci_pkg;
  localparam int COND_W = 4;

  typedef enum logic [1:0] {
    OP_SET = 2'd0,
    OP_CLR = 2'd1,
    OP_INV = 2'd2,
    OP_RSV = 2'd3
  } sci_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import cond_sci_pkg::*;
(
  input  flags_t            flags,
  input  logic [COND_W-1:0] cond,
  output logic              holds
);
  logic lt;
  assign lt = flags.n ^ flags.v;

  always_comb begin
    case (cond)
      4'h0: holds = 1'b1;
      4'h1: holds = !flags.c;
      4'h2: holds = flags.c;
      4'h3: holds = !flags.c || flags.z;
      4'h4: holds = flags.c && !flags.z;
      4'h5: holds = lt;
      4'h6: holds = !lt;
      4'h7: holds = flags.z || lt;
      4'h8: holds = !flags.z && !lt;
      4'h9: holds = flags.z;
      4'hA: holds = !flags.z;
      4'hB: holds = flags.n;
      4'hC: holds = !flags.n;
      4'hD: holds = !flags.v;
      4'hE: holds = flags.v;
      default: holds = 1'b0;
    endcase
  end
endmodule

// File: rtl/branch_decode.sv
module branch_decode
  import cond_sci_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0]  opc,
  output logic              is_branch,
  output logic [COND_W-1:0] br_cond,
  output logic              force_take
);
  localparam int CLASS_W = 5;
  localparam int TOP_W   = OPC_W - CLASS_W;
  localparam logic [CLASS_W-1:0] CLASS_LO = 5'h1C;
  localparam logic [CLASS_W-1:0] CLASS_HI = 5'h1D;

  logic [CLASS_W-1:0] cls;
  logic [TOP_W-1:0]   top;

  assign cls = opc[CLASS_W-1:0];
  assign top = opc[OPC_W-1:CLASS_W];

  always_comb begin
    is_branch  = (cls == CLASS_LO) || (cls == CLASS_HI);
    br_cond    = {(cls == CLASS_HI), top};
    force_take = (cls == CLASS_HI) && (&top);
  end
endmodule

// File: rtl/bit_modify.sv
module bit_modify
  import cond_sci_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  sci_op_e           op,
  input  logic              size_word,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] dest,
  input  logic              holds,
  output logic [DATA_W-1:0] result,
  output logic              we
);
  logic [DATA_W-1:0] lane;
  logic [DATA_W-1:0] eff_mask;
  logic [DATA_W-1:0] bool_word;
  logic              mask_zero;
  logic              bool_bit;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_lane
      if (gi < BYTE_W) begin : g_low
        assign lane[gi] = 1'b1;
      end else begin : g_high
        assign lane[gi] = size_word;
      end
    end
  endgenerate

  assign eff_mask  = mask & lane;
  assign mask_zero = (eff_mask == '0);
  assign bool_bit  = (op == OP_SET) ? holds : !holds;
  assign bool_word = (dest & ~lane) | ({{(DATA_W-1){1'b0}}, bool_bit} & lane);

  always_comb begin
    result = dest;
    we     = 1'b0;
    if (op != OP_RSV) begin
      if (mask_zero) begin
        if (op == OP_INV) begin
          we = holds;
          if (holds) result = dest ^ lane;
        end else begin
          we     = 1'b1;
          result = bool_word;
        end
      end else if (holds) begin
        we = 1'b1;
        case (op)
          OP_SET:  result = dest | eff_mask;
          OP_CLR:  result = dest & ~eff_mask;
          default: result = dest ^ eff_mask;
        endcase
      end
    end
  end
endmodule

// File: rtl/cond_sci_unit.sv
module cond_sci_unit
  import cond_sci_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int OPC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_kind,
  input  logic [OPC_W-1:0]  in_opc,
  input  logic [3:0]        in_flags,
  input  logic [COND_W-1:0] in_cond,
  input  logic [1:0]        in_op,
  input  logic              in_size_word,
  input  logic [DATA_W-1:0] in_mask,
  input  logic [DATA_W-1:0] in_dest,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_we,
  output logic              out_taken
);
  logic              is_branch, force_take, holds, mod_we, accept;
  logic [COND_W-1:0] br_cond, cond_sel;
  logic [DATA_W-1:0] mod_res;
  sci_op_e           op_e;

  assign op_e     = sci_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  branch_decode #(.OPC_W(OPC_W)) u_bdec (
    .opc(in_opc), .is_branch(is_branch), .br_cond(br_cond), .force_take(force_take)
  );

  assign cond_sel = in_kind ? br_cond : in_cond;

  cond_eval u_ceval (.flags(flags_t'(in_flags)), .cond(cond_sel), .holds(holds));

  bit_modify #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_bmod (
    .op(op_e), .size_word(in_size_word), .mask(in_mask), .dest(in_dest),
    .holds(holds), .result(mod_res), .we(mod_we)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_we    <= 1'b0;
      out_taken <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= in_kind ? in_dest : mod_res;
        out_we    <= in_kind ? 1'b0 : mod_we;
        out_taken <= in_kind && is_branch && (force_take || holds);
      end
    end
  end

  // R10: a stalled result holds steady
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_we) && $stable(out_taken)));

  // R11: an empty output register always accepts
  a_r11_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r8_bsr_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind && in_opc == 8'hFD) |=> out_taken);

  a_r9_not_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (!in_kind || (in_opc[4:0] != 5'h1C && in_opc[4:0] != 5'h1D))) |=> !out_taken);

  a_r7_branch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind) |=> (!out_we && out_data == $past(in_dest)));

  a_r12_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_kind && in_op == 2'd3) |=> (!out_we && out_data == $past(in_dest)));

  a_r6_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_kind && !in_size_word) |=> (out_data[DATA_W-1:BYTE_W] == $past(in_dest[DATA_W-1:BYTE_W])));

  a_r1_never_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_kind && in_cond == 4'hF && in_op == 2'd2) |=> !out_we);
endmodule

// File: tb/cond_sci_unit_tb.sv
module cond_sci_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;

  typedef struct packed {
    logic        kind;
    logic [7:0]  opc;
    logic [3:0]  flags;
    logic [3:0]  cond;
    logic [1:0]  op;
    logic        sw;
    logic [15:0] mask;
    logic [15:0] dest;
    logic [15:0] e_data;
    logic        e_we;
    logic        e_tk;
    logic [7:0]  req;
  } vec_t;

  // flags order N V Z C; op 0 set 1 clear 2 invert 3 reserved; sw 1 word
  localparam logic [77:0] VEC [NV] = '{
    {1'b0,8'h00,4'b0001,4'h2,2'd0,1'b1,16'h0088,16'h1200,16'h1288,1'b1,1'b0,8'd5},   // R5 set mask
    {1'b0,8'h00,4'b0000,4'h2,2'd0,1'b1,16'h0088,16'h1200,16'h1200,1'b0,1'b0,8'd5},   // R5 cond false
    {1'b0,8'h00,4'b0010,4'h9,2'd0,1'b1,16'h0000,16'hABCD,16'h0001,1'b1,1'b0,8'd2},   // R2
    {1'b0,8'h00,4'b0000,4'h9,2'd0,1'b1,16'h0000,16'hABCD,16'h0000,1'b1,1'b0,8'd2},   // R2
    {1'b0,8'h00,4'b1000,4'h5,2'd1,1'b1,16'h0000,16'h5555,16'h0000,1'b1,1'b0,8'd3},   // R3
    {1'b0,8'h00,4'b1100,4'h5,2'd1,1'b1,16'h0000,16'h5555,16'h0001,1'b1,1'b0,8'd3},   // R3
    {1'b0,8'h00,4'b0000,4'h0,2'd2,1'b1,16'h0000,16'h0F0F,16'hF0F0,1'b1,1'b0,8'd4},   // R4
    {1'b0,8'h00,4'b1111,4'hF,2'd2,1'b1,16'h0000,16'h0F0F,16'h0F0F,1'b0,1'b0,8'd4},   // R4 never
    {1'b0,8'h00,4'b0001,4'h4,2'd1,1'b1,16'h00F0,16'h12FF,16'h120F,1'b1,1'b0,8'd5},   // R5 clear
    {1'b0,8'h00,4'b0011,4'h3,2'd2,1'b1,16'hFF00,16'h1234,16'hED34,1'b1,1'b0,8'd5},   // R5 invert
    {1'b0,8'h00,4'b0001,4'h4,2'd2,1'b1,16'h00F0,16'h1234,16'h12C4,1'b1,1'b0,8'd5},   // R5 HI invert
    {1'b0,8'h00,4'b0000,4'h0,2'd2,1'b0,16'h0000,16'hAB12,16'hABED,1'b1,1'b0,8'd6},   // R6 byte inv
    {1'b0,8'h00,4'b0000,4'h0,2'd0,1'b0,16'hFF00,16'h5500,16'h5501,1'b1,1'b0,8'd6},   // R6 high mask ignored
    {1'b0,8'h00,4'b0000,4'h0,2'd0,1'b0,16'h0000,16'h77FF,16'h7701,1'b1,1'b0,8'd6},   // R6 boolean
    {1'b0,8'h00,4'b0000,4'h0,2'd0,1'b0,16'h0F0F,16'h9900,16'h990F,1'b1,1'b0,8'd6},   // R6 byte set mask
    {1'b0,8'h00,4'b0000,4'h8,2'd0,1'b1,16'h0000,16'h0000,16'h0001,1'b1,1'b0,8'd1},   // R1 GT
    {1'b0,8'h00,4'b0010,4'h8,2'd0,1'b1,16'h0000,16'h0000,16'h0000,1'b1,1'b0,8'd1},   // R1 GT false
    {1'b0,8'h00,4'b0100,4'h7,2'd0,1'b1,16'h0000,16'h0000,16'h0001,1'b1,1'b0,8'd1},   // R1 LE
    {1'b0,8'h00,4'b0100,4'hD,2'd0,1'b1,16'h0000,16'h0000,16'h0000,1'b1,1'b0,8'd1},   // R1 VC
    {1'b0,8'h00,4'b0100,4'hE,2'd0,1'b1,16'h0000,16'h0000,16'h0001,1'b1,1'b0,8'd1},   // R1 VS
    {1'b0,8'h00,4'b1000,4'hB,2'd0,1'b1,16'h0000,16'h0000,16'h0001,1'b1,1'b0,8'd1},   // R1 MI
    {1'b0,8'h00,4'b1000,4'hC,2'd0,1'b1,16'h0000,16'h0000,16'h0000,1'b1,1'b0,8'd1},   // R1 PL
    {1'b0,8'h00,4'b0000,4'h1,2'd0,1'b1,16'h0000,16'h0000,16'h0001,1'b1,1'b0,8'd1},   // R1 CC
    {1'b0,8'h00,4'b1100,4'h6,2'd0,1'b1,16'h0000,16'h0000,16'h0001,1'b1,1'b0,8'd1},   // R1 GE
    {1'b0,8'h00,4'b0000,4'hA,2'd0,1'b1,16'h0000,16'h0000,16'h0001,1'b1,1'b0,8'd1},   // R1 NE
    {1'b0,8'h00,4'b0000,4'h0,2'd3,1'b1,16'h00FF,16'h4444,16'h4444,1'b0,1'b0,8'd12},  // R12
    {1'b1,8'h5C,4'b0001,4'h0,2'd0,1'b1,16'h0000,16'h3333,16'h3333,1'b0,1'b1,8'd7},   // R7 CS taken
    {1'b1,8'h5C,4'b0000,4'h0,2'd0,1'b1,16'h0000,16'h3333,16'h3333,1'b0,1'b0,8'd7},   // R7 CS not
    {1'b1,8'h3D,4'b0010,4'h0,2'd0,1'b1,16'h0000,16'h0000,16'h0000,1'b0,1'b1,8'd7},   // R7 EQ
    {1'b1,8'hFC,4'b0000,4'h0,2'd0,1'b1,16'h0000,16'h0000,16'h0000,1'b0,1'b0,8'd7},   // R7 LE false
    {1'b1,8'h1D,4'b0000,4'h0,2'd0,1'b1,16'h0000,16'h0000,16'h0000,1'b0,1'b1,8'd7},   // R7 GT
    {1'b1,8'hFD,4'b0000,4'h0,2'd0,1'b1,16'h0000,16'h0000,16'h0000,1'b0,1'b1,8'd8},   // R8 subroutine
    {1'b1,8'h1E,4'b1111,4'h0,2'd0,1'b1,16'h0000,16'h0000,16'h0000,1'b0,1'b0,8'd9}    // R9 not branch
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_kind = 1'b0, in_size_word = 1'b1, out_ready = 1'b1;
  logic [7:0] in_opc = '0;
  logic [3:0] in_flags = '0, in_cond = '0;
  logic [1:0] in_op = '0;
  logic [15:0] in_mask = '0, in_dest = '0;
  logic in_ready, out_valid, out_we, out_taken;
  logic [15:0] out_data;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_sci_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_opc(in_opc), .in_flags(in_flags), .in_cond(in_cond),
    .in_op(in_op), .in_size_word(in_size_word), .in_mask(in_mask), .in_dest(in_dest),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_we(out_we), .out_taken(out_taken)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_kind = v.kind; in_opc = v.opc; in_flags = v.flags; in_cond = v.cond;
    in_op = v.op; in_size_word = v.sw; in_mask = v.mask; in_dest = v.dest;
    in_valid = 1'b1;
  endtask

  task automatic check_vec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " data"}, {16'd0, out_data}, {16'd0, v.e_data});
    chk({tag, " we"}, {31'd0, out_we}, {31'd0, v.e_we});
    chk({tag, " taken"}, {31'd0, out_taken}, {31'd0, v.e_tk});
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vec_t a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R11 in_ready after reset", {31'd0, in_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      @(negedge clk);
      drive(v);
      @(negedge clk);
      check_vec(v);
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 idle out_valid", {31'd0, out_valid}, 32'd0);

    // R10 stall: output held, input blocked, next result one edge after release
    a = vec_t'(VEC[0]);
    b = vec_t'(VEC[6]);
    out_ready = 1'b0;
    drive(a);
    @(negedge clk);
    check_vec(a);
    chk("R10 in_ready stalled", {31'd0, in_ready}, 32'd0);
    drive(b);
    repeat (3) begin
      @(negedge clk);
      chk("R10 held data", {16'd0, out_data}, {16'd0, a.e_data});
      chk("R10 held we", {31'd0, out_we}, {31'd0, a.e_we});
      chk("R10 stall in_ready", {31'd0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check_vec(b);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 drained", {31'd0, out_valid}, 32'd0);

    // R11 reset mid-stream clears result
    drive(a);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 in_ready after reset", {31'd0, in_ready}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule